// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Counter Cascade

This block is a chain of identical four-bit counting stages that share one clock. Each stage counts in either plain binary (modulo 16) or as a BCD decade (modulo 10), up or down. The modulus and the direction are chosen at run time by two level inputs that every stage sees.

A shared preset input loads every stage from its own four jam lines asynchronously, without waiting for a clock. An active-low enable input starts the chain. Each stage produces an active-low look-ahead carry and passes it to the next stage as that stage's enable, so the whole chain advances on one common clock edge. The carry of the last stage is brought out so that further chains can be attached.

Each stage is a two-state machine:
- ST_LOAD is entered asynchronously whenever preset is high.
- The transition LOAD_TO_RUN is taken on the first rising clock edge that finds preset low. That edge does not count.
- In ST_RUN, the transition RUN_STEP is taken on an edge where the stage's enable is low, and the stage advances by one.
- The transition RUN_HOLD is taken on any other edge, and the stage keeps its value.

Top module: `cnt_cascade`

## Requirements
- R1: While `preset_en` is high, `q` equals `jam` at once, with no clock edge needed. An all-zero `jam` gives a zero count.
- R2: The stage register takes `jam` when `preset_en` rises and again on every rising edge while `preset_en` is high. The first rising edge that finds `preset_en` low only leaves the load state and does not change `q`.
- R3: While `carry_in` is high, no stage changes value on a clock edge, and `carry_out` is high.
- R4: With `bin_mode` low (decade), each four-bit digit counts 0 to 9. Going up, 9 wraps to 0. Going down, 0 wraps to 9.
- R5: With `bin_mode` high (binary), each digit counts 0 to 15. Going up, 15 wraps to 0. Going down, 0 wraps to 15.
- R6: `carry_out` is low exactly when `carry_in` is low and every stage is at its terminal value. The terminal value is 15 (binary) or 9 (decade) when `count_up` is high, and 0 when it is low.
- R7: In decade mode, a digit holding 10 to 15 goes to 0 on the next enabled edge when counting up. When counting down it decreases by one. Such a digit is never terminal.
- R8: Digit `i` (bits `4*i+3:4*i`, digit 0 least significant) advances on an edge only when `carry_in` is low and every lower digit is at its terminal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common counting clock, rising edge |
| carry_in | input | 1 | Active-low enable into the first stage |
| bin_mode | input | 1 | 1 = binary modulo 16, 0 = decade modulo 10 |
| count_up | input | 1 | 1 = count up, 0 = count down |
| preset_en | input | 1 | Asynchronous load of all stages from `jam` |
| jam | input | 4*STAGES | Parallel load values, four bits per stage |
| q | output | 4*STAGES | Count value, four bits per stage |
| carry_out | output | 1 | Active-low carry of the last stage |

## Verification
The assertions watch four things on every cycle:
- `q` mirrors `jam` while preset is high.
- A high `carry_in` freezes the count and keeps the carry high.
- A decade digit that is in range stays in range.
- A low `carry_out` implies the terminal value on the top digit for the current mode and direction.

Only the bench's scenarios can show the rest: the exact sequences, the wrap points in both moduli, the non-counting release edge, the handling of out-of-range decade digits, and a preset that arrives in the middle of a count. They do this by comparing every edge against a digit-by-digit reference model.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } stage_st_e;
endpackage

// File: rtl/cnt_step.sv
module cnt_step
    import cnt_pkg::*;
(
    input  digit_t cur,
    input  logic   bin_mode,
    input  logic   count_up,
    output digit_t nxt
);
    localparam digit_t DEC_TOP = digit_t'(9);
    localparam digit_t BIN_TOP = digit_t'(15);

    always_comb begin
        if (count_up) begin
            if (bin_mode)
                nxt = (cur == BIN_TOP) ? '0 : cur + digit_t'(1);
            else
                nxt = (cur >= DEC_TOP) ? '0 : cur + digit_t'(1);
        end else begin
            if (cur == '0)
                nxt = bin_mode ? BIN_TOP : DEC_TOP;
            else
                nxt = cur - digit_t'(1);
        end
    end
endmodule

// File: rtl/cnt_term.sv
module cnt_term
    import cnt_pkg::*;
(
    input  digit_t cur,
    input  logic   bin_mode,
    input  logic   count_up,
    input  logic   en_n,
    output logic   co_n
);
    logic at_end;

    always_comb begin
        if (count_up)
            at_end = bin_mode ? (cur == digit_t'(15)) : (cur == digit_t'(9));
        else
            at_end = (cur == '0);
        co_n = ~(at_end & ~en_n);
    end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
(
    input  logic   clk,
    input  logic   preset_en,
    input  logic   en_n,
    input  logic   bin_mode,
    input  logic   count_up,
    input  digit_t jam,
    output digit_t q,
    output logic   co_n
);
    stage_st_e st_q, st_d;
    digit_t    val_q, val_d, step_val;

    cnt_step u_step (
        .cur      (val_q),
        .bin_mode (bin_mode),
        .count_up (count_up),
        .nxt      (step_val)
    );

    // State register: preset forces the load state asynchronously.
    always_ff @(posedge clk or posedge preset_en) begin
        if (preset_en) begin
            st_q  <= ST_LOAD;
            val_q <= jam;
        end else begin
            st_q  <= st_d;
            val_q <= val_d;
        end
    end

    // Transitions: LOAD_TO_RUN, RUN_STEP, RUN_HOLD.
    always_comb begin
        st_d  = st_q;
        val_d = val_q;
        unique case (st_q)
            ST_LOAD: st_d = ST_RUN;
            ST_RUN:  if (!en_n) val_d = step_val;
            default: st_d = ST_LOAD;
        endcase
    end

    // Outputs: the jam value shows through while preset is high.
    always_comb begin
        q = preset_en ? jam : val_q;
    end

    cnt_term u_term (
        .cur      (q),
        .bin_mode (bin_mode),
        .count_up (count_up),
        .en_n     (en_n),
        .co_n     (co_n)
    );
endmodule

// File: rtl/cnt_cascade.sv
module cnt_cascade
    import cnt_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic                    clk,
    input  logic                    carry_in,
    input  logic                    bin_mode,
    input  logic                    count_up,
    input  logic                    preset_en,
    input  logic [DIGIT_W*STAGES-1:0] jam,
    output logic [DIGIT_W*STAGES-1:0] q,
    output logic                    carry_out
);
    logic [STAGES:0] chain_n;

    assign chain_n[0] = carry_in;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        cnt_stage u_stage (
            .clk       (clk),
            .preset_en (preset_en),
            .en_n      (chain_n[i]),
            .bin_mode  (bin_mode),
            .count_up  (count_up),
            .jam       (jam[DIGIT_W*i +: DIGIT_W]),
            .q         (q[DIGIT_W*i +: DIGIT_W]),
            .co_n      (chain_n[i+1])
        );
    end

    assign carry_out = chain_n[STAGES];
endmodule

// File: rtl/cnt_cascade_chk.sv
module cnt_cascade_chk #(
    parameter int STAGES = 3
) (
    input logic                  clk,
    input logic                  carry_in,
    input logic                  bin_mode,
    input logic                  count_up,
    input logic                  preset_en,
    input logic [4*STAGES-1:0]   jam,
    input logic [4*STAGES-1:0]   q,
    input logic                  carry_out
);
    localparam int TOP = 4*STAGES-1;

    always @(negedge clk) begin
        if (preset_en) begin
            AST_LOAD_VISIBLE: assert (q == jam); // R1
        end
    end

    AST_HOLD_ON_CIN: assert property (@(posedge clk) disable iff (preset_en)
        carry_in |=> $stable(q)); // R3

    AST_CARRY_GATED: assert property (@(posedge clk) disable iff (preset_en)
        carry_in |-> carry_out); // R3

    AST_DEC_RANGE: assert property (@(posedge clk) disable iff (preset_en)
        (!bin_mode && q[3:0] <= 4'd9) |=> (q[3:0] <= 4'd9)); // R4

    AST_TERM_BIN_UP: assert property (@(posedge clk) disable iff (preset_en)
        (!carry_out && count_up && bin_mode) |-> (q[TOP -: 4] == 4'hF)); // R6

    AST_TERM_DEC_UP: assert property (@(posedge clk) disable iff (preset_en)
        (!carry_out && count_up && !bin_mode) |-> (q[TOP -: 4] == 4'd9)); // R6

    AST_TERM_DOWN: assert property (@(posedge clk) disable iff (preset_en)
        (!carry_out && !count_up) |-> (q[TOP -: 4] == 4'd0)); // R6
endmodule

bind cnt_cascade cnt_cascade_chk #(.STAGES(STAGES)) u_chk (.*);

// File: tb/sim_cnt_cascade.sv
`timescale 1ns/1ps
module sim_cnt_cascade;
    localparam int STG = 3;
    localparam int W   = 4*STG;

    logic         clk = 1'b0;
    logic         carry_in = 1'b0;
    logic         bin_mode = 1'b0;
    logic         count_up = 1'b1;
    logic         preset_en = 1'b1;
    logic [W-1:0] jam = '0;
    logic [W-1:0] q;
    logic         carry_out;

    int checks = 0;
    int failures = 0;
    int dig [STG];
    bit loaded = 1'b1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cnt_cascade #(.STAGES(STG)) u0 (
        .clk(clk), .carry_in(carry_in), .bin_mode(bin_mode),
        .count_up(count_up), .preset_en(preset_en), .jam(jam),
        .q(q), .carry_out(carry_out)
    );

    function automatic int nxt_dig(int d, bit bin, bit up);
        if (up) return bin ? ((d == 15) ? 0 : d + 1) : ((d >= 9) ? 0 : d + 1);
        return (d == 0) ? (bin ? 15 : 9) : d - 1;
    endfunction

    function automatic bit is_term(int d, bit bin, bit up);
        if (up) return bin ? (d == 15) : (d == 9);
        return d == 0;
    endfunction

    function automatic logic [W-1:0] exp_q();
        logic [W-1:0] v;
        for (int i = 0; i < STG; i++) v[4*i +: 4] = 4'(dig[i]);
        return v;
    endfunction

    function automatic logic exp_co();
        bit en = !carry_in;
        for (int i = 0; i < STG; i++) en = en && is_term(dig[i], bin_mode, count_up);
        return !en;
    endfunction

    task automatic load_model();
        for (int i = 0; i < STG; i++) dig[i] = int'(jam[4*i +: 4]);
    endtask

    task automatic chk(string tag);
        checks++;
        if (q !== exp_q() || carry_out !== exp_co()) begin
            failures++;
            $display("FAIL %s q=%h co=%b expected q=%h co=%b", tag, q, carry_out, exp_q(), exp_co());
        end
    endtask

    // One clock edge: model updated from inputs held across the edge, check at negedge.
    task automatic edge_chk(string tag);
        @(posedge clk);
        if (preset_en) begin
            load_model();
            loaded = 1'b1;
        end else if (loaded) begin
            loaded = 1'b0;
        end else begin
            bit en = !carry_in;
            int old [STG];
            for (int i = 0; i < STG; i++) old[i] = dig[i];
            for (int i = 0; i < STG; i++) begin
                if (en) dig[i] = nxt_dig(old[i], bin_mode, count_up);
                en = en && is_term(old[i], bin_mode, count_up);
            end
        end
        @(negedge clk);
        #0.5;
        chk(tag);
    endtask

    task automatic do_preset(logic [W-1:0] v);
        @(negedge clk);
        jam = v;
        preset_en = 1'b1;
        #0.5;
        load_model();
        loaded = 1'b1;
        chk("R1 async preset");
        edge_chk("R2 edge while preset");
        preset_en = 1'b0;
        #0.5;
        chk("R2 release");
        edge_chk("R2 first edge after release holds");
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Reset state through the preset with all jam lines low.
        load_model();
        #1;
        chk("R1 zero jam");
        edge_chk("R1 reset");
        edge_chk("R1 reset");

        // Decade up over the full 000..999 range and wrap.
        bin_mode = 1'b0;
        count_up = 1'b1;
        carry_in = 1'b0;
        do_preset('0);
        for (int n = 0; n < 1000; n++) begin
            if (exp_q() == 12'h999) begin
                #0.5;
                chk("R6 carry low at 999");
            end
            edge_chk("R4 R8 decade up");
        end

        // Binary down from zero wraps to FFF.
        bin_mode = 1'b1;
        count_up = 1'b0;
        #0.5;
        chk("R6 carry low at 000 down");
        edge_chk("R5 binary wrap down");
        for (int n = 0; n < 300; n++) edge_chk("R5 R8 binary down");
        count_up = 1'b1;
        for (int n = 0; n < 300; n++) edge_chk("R5 binary up");

        // Carry-in high freezes the count.
        carry_in = 1'b1;
        #0.5;
        chk("R3 carry gated");
        for (int n = 0; n < 20; n++) edge_chk("R3 hold");
        carry_in = 1'b0;

        // Out-of-range decade digits.
        bin_mode = 1'b0;
        count_up = 1'b1;
        do_preset(12'h0FC);
        #0.5;
        chk("R7 not terminal");
        edge_chk("R7 up from 12 to 0");
        do_preset(12'h00A);
        count_up = 1'b0;
        edge_chk("R7 down from 10");
        edge_chk("R7 down from 9");

        // Preset in the middle of a count, jam changing while held.
        count_up = 1'b1;
        for (int n = 0; n < 7; n++) edge_chk("R4 pre");
        @(negedge clk);
        jam = 12'h555;
        preset_en = 1'b1;
        #0.5;
        load_model();
        chk("R1 mid-count preset");
        #0.5;
        jam = 12'h321;
        #0.5;
        load_model();
        chk("R1 jam follows");
        edge_chk("R2 capture on edge");
        preset_en = 1'b0;
        edge_chk("R2 release edge");
        edge_chk("R4 after release");

        // Constrained random phase.
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 100);
            carry_in = ($urandom % 4) == 0;
            if (r < 5) count_up = ~count_up;
            if (r >= 5 && r < 8) bin_mode = ~bin_mode;
            if (r >= 8 && r < 10) begin
                do_preset(W'($urandom));
            end else begin
                #0.5;
                chk("R6 random carry");
                edge_chk("R8 random");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule